// File: doc/BRIEF.md
# Secured PROM Read Port with Address Remap

This block sits between a bus master and a 64 KB PROM array and serves single-byte reads. The master chooses one of two address views with a mode input, sampled with each request. In processor view a 24-bit address is decoded. Addresses inside the PROM window are shifted down to a zero-based array offset. Everything outside the window is reported as a miss. In programmer view a 17-bit address is taken as the offset directly, and its upper half is an unused region.

On leaving reset the block reads array offset zero once and keeps bit 0 of that byte as the protection flag. It accepts no request until this fetch is done. When the flag is 0, every programmer-view read returns FFh. Processor-view reads still return the true array contents.

Every read, the initial fetch included, holds the array address for a fixed number of wait cycles set by a parameter. The result is returned with a one-cycle ready pulse. The array is modelled as a read port whose data follows the address it is given.

Top module: `prom_read_port`

## Requirements
- R1: During reset `rd_ready` and `rd_hit` are 0, `rd_data` is FFh and `req_ok` is 0. After reset is released, `arr_addr` is 0 while the offset-zero fetch runs. `req_ok` rises exactly WAIT_CYC clock edges after the first edge with reset released.
- R2: `req_ok` is 1 only while the block is idle. A request is taken on a clock edge where `rd_req` and `req_ok` are both 1.
- R3: In processor view (`pgm_mode`=0), an address from 008000h to 017FFFh gives `rd_hit`=1. It reads array offset (address − 008000h), so 008000h reads offset 0000h and 017FFFh reads offset FFFFh.
- R4: In processor view, any address below 008000h gives `rd_hit`=0 and `rd_data`=FFh. This covers the I/O range 000000h–00007Fh and the RAM range 000080h–00087Fh. Any address above 017FFFh gives the same result.
- R5: In programmer view (`pgm_mode`=1), an address from 00000h to 0FFFFh gives `rd_hit`=1 and reads that same array offset.
- R6: In programmer view, an address from 10000h to 1FFFFh gives `rd_hit`=0 and `rd_data`=FFh.
- R7: The protection flag is bit 0 of the byte at offset 0, captured once after each reset. When it is 0, programmer-view reads return FFh with `rd_hit` still 1. Processor-view reads are unaffected.
- R8: `rd_ready` is a single-cycle pulse. It is 1 on the WAIT_CYC-th clock edge after the accepting edge, and `req_ok` stays 0 from the accepting edge until that pulse.
- R9: A request made while `req_ok` is 0 is dropped. It produces no ready pulse of its own.
- R10: `rd_data` and `rd_hit` change only on the edge that raises `rd_ready`, and hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pgm_mode | input | 1 | 1 = programmer view, 0 = processor view; sampled with the request |
| rd_req | input | 1 | Read request, taken when req_ok is 1 |
| cpu_addr | input | 24 | Processor-view byte address |
| pgm_addr | input | 17 | Programmer-view byte address |
| req_ok | output | 1 | Block is idle and will take a request |
| arr_addr | output | 16 | Offset presented to the PROM array |
| arr_rdata | input | 8 | Byte returned by the PROM array for arr_addr |
| rd_data | output | 8 | Result of the last completed read |
| rd_hit | output | 1 | Last completed read fell inside a PROM window |
| rd_ready | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `arr_rdata` follows `arr_addr` within the wait period. They also assume that the master does not count on a request made while `req_ok` is low. The bench's array model is a pure function of the offset, so the first condition always holds. Requests are normally raised only after `req_ok` has been seen high. The one exception is the drop scenario, which raises a request on purpose while the block is busy and checks, through the ready pulse and the returned data, that the request left no trace.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;
  localparam int DEF_CPU_AW = 24;
  localparam int DEF_PGM_AW = 17;
  localparam int DEF_OFS_W  = 16;
  localparam int DEF_DW     = 8;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAIT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/prom_win_decode.sv
module prom_win_decode #(
  parameter int CPU_AW = prom_rd_pkg::DEF_CPU_AW,
  parameter int PGM_AW = prom_rd_pkg::DEF_PGM_AW,
  parameter int OFS_W  = prom_rd_pkg::DEF_OFS_W,
  parameter logic [CPU_AW-1:0] CPU_BASE = CPU_AW'(32'h008000)
) (
  input  logic              pgm_mode,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [PGM_AW-1:0] pgm_addr,
  output logic              dec_hit,
  output logic [OFS_W-1:0]  dec_ofs
);
  localparam logic [CPU_AW:0] WIN_LO = {1'b0, CPU_BASE};
  localparam logic [CPU_AW:0] WIN_HI = WIN_LO + ((CPU_AW+1)'(1) << OFS_W);

  function automatic logic cpu_in_win(input logic [CPU_AW-1:0] a);
    logic [CPU_AW:0] wa;
    wa = {1'b0, a};
    return (wa >= WIN_LO) && (wa < WIN_HI);
  endfunction

  function automatic logic [OFS_W-1:0] cpu_to_ofs(input logic [CPU_AW-1:0] a);
    logic [CPU_AW-1:0] d;
    d = a - CPU_BASE;
    return d[OFS_W-1:0];
  endfunction

  function automatic logic pgm_in_win(input logic [PGM_AW-1:0] a);
    return a[PGM_AW-1:OFS_W] == '0;
  endfunction

  always_comb begin
    if (pgm_mode) begin
      dec_hit = pgm_in_win(pgm_addr);
      dec_ofs = pgm_addr[OFS_W-1:0];
    end else begin
      dec_hit = cpu_in_win(cpu_addr);
      dec_ofs = cpu_to_ofs(cpu_addr);
    end
  end
endmodule

// File: rtl/prom_sec_reg.sv
module prom_sec_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic cap_bit,
  output logic sec_open
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sec_open <= 1'b0;
    else if (cap_en) sec_open <= cap_bit;
  end

  // R7
  sec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(sec_open));
endmodule

// File: rtl/prom_rd_seq.sv
module prom_rd_seq
  import prom_rd_pkg::*;
#(
  parameter int OFS_W    = DEF_OFS_W,
  parameter int DW       = DEF_DW,
  parameter int WAIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic             pgm_mode,
  input  logic             dec_hit,
  input  logic [OFS_W-1:0] dec_ofs,
  input  logic             sec_open,
  input  logic [DW-1:0]    arr_rdata,
  output logic             req_ok,
  output logic             boot_cap,
  output logic [OFS_W-1:0] arr_addr,
  output logic [DW-1:0]    rd_data,
  output logic             rd_hit,
  output logic             rd_ready
);
  localparam int CW = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

  rd_state_e        state;
  logic [CW-1:0]    cnt;
  logic [OFS_W-1:0] ofs_q;
  logic             hit_q, pgm_q;
  logic             take, last_cyc, blank;

  assign req_ok   = (state == ST_IDLE);
  assign take     = req_ok && rd_req;
  assign last_cyc = (cnt == LAST);
  assign boot_cap = (state == ST_BOOT) && last_cyc;
  assign blank    = !hit_q || (pgm_q && !sec_open);
  assign arr_addr = (state == ST_BOOT) ? '0 : ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_BOOT;
      cnt      <= '0;
      ofs_q    <= '0;
      hit_q    <= 1'b0;
      pgm_q    <= 1'b0;
      rd_data  <= '1;
      rd_hit   <= 1'b0;
      rd_ready <= 1'b0;
    end else begin
      rd_ready <= 1'b0;
      unique case (state)
        ST_BOOT: begin
          cnt <= last_cyc ? '0 : cnt + 1'b1;
          if (last_cyc) state <= ST_IDLE;
        end
        ST_IDLE: begin
          cnt <= '0;
          if (take) begin
            ofs_q <= dec_ofs;
            hit_q <= dec_hit;
            pgm_q <= pgm_mode;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          cnt <= last_cyc ? '0 : cnt + 1'b1;
          if (last_cyc) begin
            rd_data  <= blank ? '1 : arr_rdata;
            rd_hit   <= hit_q;
            rd_ready <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  boot_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BOOT) |-> (arr_addr == '0) && !req_ok);
  // R8
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);
  // R8
  ready_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !$past(req_ok));
  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ready |-> $stable(rd_data) && $stable(rd_hit));
endmodule

// File: rtl/prom_read_port.sv
module prom_read_port
  import prom_rd_pkg::*;
#(
  parameter int CPU_AW   = DEF_CPU_AW,
  parameter int PGM_AW   = DEF_PGM_AW,
  parameter int OFS_W    = DEF_OFS_W,
  parameter int DW       = DEF_DW,
  parameter int WAIT_CYC = 2,
  parameter logic [CPU_AW-1:0] CPU_BASE = CPU_AW'(32'h008000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_mode,
  input  logic              rd_req,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [PGM_AW-1:0] pgm_addr,
  output logic              req_ok,
  output logic [OFS_W-1:0]  arr_addr,
  input  logic [DW-1:0]     arr_rdata,
  output logic [DW-1:0]     rd_data,
  output logic              rd_hit,
  output logic              rd_ready
);
  logic             dec_hit;
  logic [OFS_W-1:0] dec_ofs;
  logic             boot_cap;
  logic             sec_open;
  logic             pgm_q_seen;

  prom_win_decode #(
    .CPU_AW(CPU_AW), .PGM_AW(PGM_AW), .OFS_W(OFS_W), .CPU_BASE(CPU_BASE)
  ) dec_i (
    .pgm_mode(pgm_mode), .cpu_addr(cpu_addr), .pgm_addr(pgm_addr),
    .dec_hit(dec_hit), .dec_ofs(dec_ofs)
  );

  prom_sec_reg sec_i (
    .clk(clk), .rst_n(rst_n), .cap_en(boot_cap),
    .cap_bit(arr_rdata[0]), .sec_open(sec_open)
  );

  prom_rd_seq #(.OFS_W(OFS_W), .DW(DW), .WAIT_CYC(WAIT_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .pgm_mode(pgm_mode),
    .dec_hit(dec_hit), .dec_ofs(dec_ofs), .sec_open(sec_open),
    .arr_rdata(arr_rdata), .req_ok(req_ok), .boot_cap(boot_cap),
    .arr_addr(arr_addr), .rd_data(rd_data), .rd_hit(rd_hit),
    .rd_ready(rd_ready)
  );

  // mode of the request in flight, tracked here for the protection check
  always_ff @(posedge clk) begin
    if (!rst_n)                 pgm_q_seen <= 1'b0;
    else if (req_ok && rd_req)  pgm_q_seen <= pgm_mode;
  end

  // R4
  miss_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_hit) |-> (rd_data == '1));
  // R7
  locked_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && pgm_q_seen && !sec_open) |-> (rd_data == '1));
  // R2
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && rd_req) |=> !req_ok);
endmodule

// File: tb/prom_read_port_tb.sv
module prom_read_port_tb_top;
  localparam int WAIT_CYC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pgm_mode = 1'b0;
  logic        rd_req = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [16:0] pgm_addr = '0;
  logic        req_ok;
  logic [15:0] arr_addr;
  logic [7:0]  arr_rdata;
  logic [7:0]  rd_data;
  logic        rd_hit;
  logic        rd_ready;
  logic [7:0]  sec_byte = 8'hA5;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [15:0] o);
    if (o == 16'h0000) return sec_byte;
    return o[7:0] ^ {o[11:8], o[15:12]} ^ 8'h3C;
  endfunction

  assign arr_rdata = rom_byte(arr_addr);

  prom_read_port #(.WAIT_CYC(WAIT_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pgm_mode(pgm_mode), .rd_req(rd_req),
    .cpu_addr(cpu_addr), .pgm_addr(pgm_addr), .req_ok(req_ok),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
    .rd_hit(rd_hit), .rd_ready(rd_ready)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // R1: reset values, boot fetch of offset 0, req_ok latency
  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_ready == 0 && rd_hit == 0 && req_ok == 0, "R1", "ctrl in reset",
        {rd_ready, rd_hit, req_ok}, 0);
    chk(rd_data == 8'hFF, "R1", "data in reset", rd_data, 8'hFF);
    rst_n = 1'b1;
    n = 0;
    while (!req_ok && n < 20) begin
      @(negedge clk);
      n++;
      if (!req_ok) chk(arr_addr == 0, "R1", "boot addr", arr_addr, 0);
    end
    chk(n == WAIT_CYC, "R1", "req_ok latency", n, WAIT_CYC);
  endtask

  task automatic rd(input bit m, input logic [23:0] a, input bit eh,
                    input logic [7:0] ed, input string rq);
    int n;
    n = 0;
    while (!req_ok && n < 50) begin @(negedge clk); n++; end
    pgm_mode = m;
    cpu_addr = m ? 24'h0 : a;
    pgm_addr = m ? a[16:0] : 17'h0;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(req_ok == 0, "R2", "req_ok after accept", req_ok, 0);
    n = 1;
    while (!rd_ready && n < 50) begin @(negedge clk); n++; end
    // R8: accepting edge plus WAIT_CYC edges, seen one negedge later each
    chk(n == WAIT_CYC + 1, "R8", "ready latency", n, WAIT_CYC + 1);
    chk(rd_hit == eh, rq, $sformatf("hit @%0h", a), rd_hit, eh);
    chk(rd_data == ed, rq, $sformatf("data @%0h", a), rd_data, ed);
    @(negedge clk);
    chk(rd_ready == 0, "R8", "ready one cycle", rd_ready, 0);
  endtask

  task automatic t_cpu_hits();
    rd(0, 24'h008000, 1, rom_byte(16'h0000), "R3");
    rd(0, 24'h017FFF, 1, rom_byte(16'hFFFF), "R3");
    rd(0, 24'h012345, 1, rom_byte(16'hA345), "R3");
  endtask

  task automatic t_cpu_misses();
    rd(0, 24'h000000, 0, 8'hFF, "R4");
    rd(0, 24'h00007F, 0, 8'hFF, "R4");
    rd(0, 24'h000080, 0, 8'hFF, "R4");
    rd(0, 24'h00087F, 0, 8'hFF, "R4");
    rd(0, 24'h007FFF, 0, 8'hFF, "R4");
    rd(0, 24'h018000, 0, 8'hFF, "R4");
    rd(0, 24'hFFFFFF, 0, 8'hFF, "R4");
  endtask

  task automatic t_pgm_hits();
    rd(1, 24'h00000, 1, rom_byte(16'h0000), "R5");
    rd(1, 24'h0ABCD, 1, rom_byte(16'hABCD), "R5");
    rd(1, 24'h0FFFF, 1, rom_byte(16'hFFFF), "R5");
  endtask

  task automatic t_pgm_unused();
    rd(1, 24'h10000, 0, 8'hFF, "R6");
    rd(1, 24'h1FFFF, 0, 8'hFF, "R6");
  endtask

  // R9: a request while busy is dropped
  task automatic t_drop();
    int pulses;
    while (!req_ok) @(negedge clk);
    pgm_mode = 0; cpu_addr = 24'h009111; rd_req = 1'b1;
    @(negedge clk);
    cpu_addr = 24'h00A222;
    @(negedge clk);
    rd_req = 1'b0;
    pulses = 0;
    for (int i = 0; i < 3 * WAIT_CYC + 6; i++) begin
      if (rd_ready) pulses++;
      @(negedge clk);
    end
    chk(pulses == 1, "R9", "ready pulses", pulses, 1);
    chk(rd_data == rom_byte(16'h1111), "R9", "data of first req", rd_data,
        rom_byte(16'h1111));
    chk(req_ok == 1, "R9", "idle after drop", req_ok, 1);
  endtask

  // R10: results hold between pulses while inputs move
  task automatic t_hold();
    rd(0, 24'h00C0DE, 1, rom_byte(16'h40DE), "R3");
    cpu_addr = 24'h000010;
    pgm_mode = 1;
    pgm_addr = 17'h1F000;
    repeat (5) @(negedge clk);
    chk(rd_data == rom_byte(16'h40DE), "R10", "data held", rd_data,
        rom_byte(16'h40DE));
    chk(rd_hit == 1, "R10", "hit held", rd_hit, 1);
  endtask

  // R7: protection flag from offset 0
  task automatic t_secure();
    sec_byte = 8'hFE;
    t_reset();
    rd(1, 24'h0ABCD, 1, 8'hFF, "R7");
    rd(1, 24'h00000, 1, 8'hFF, "R7");
    rd(0, 24'h012345, 1, rom_byte(16'hA345), "R7");
    rd(0, 24'h008000, 1, 8'hFE, "R7");
    sec_byte = 8'h01;
    rd(1, 24'h0ABCD, 1, 8'hFF, "R7");
    t_reset();
    rd(1, 24'h0ABCD, 1, rom_byte(16'hABCD), "R7");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_cpu_hits();
    t_cpu_misses();
    t_pgm_hits();
    t_pgm_unused();
    t_drop();
    t_hold();
    t_secure();
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule